// File: doc/BRIEF.md
# Voltage ID Startup Sequencer

This block is the digital control core of a voltage regulator. It keeps the regulator's drivers off until two power-on-reset flags are both true. On the rising edge of the enable pin it takes a two-bit boot selection from two configuration pins that are otherwise used as serial lines. It looks that selection up in a four-entry parameter table, stores the result, and soft-starts a digital reference code from zero up to it. Power-good goes high when the reference reaches the boot level.

Once power-good is high and the processor-ready input is high, the block takes new target codes on a valid/ready command port. It moves the reference toward each new target one code step per prescaled tick. When processor-ready drops, the reference slews back to the stored boot code. When enable drops or either POR flag drops, everything shuts down.

With the default parameters (3.75 mV per code, a 125 MHz clock, and 250 cycles per tick) one step per tick gives 1.875 mV/us. The command port applies back-pressure through `cmd_ready`. That signal is high only when power-good and processor-ready are both high. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, a held `cmd_valid` has no effect.

Top module: `vid_startup_seq`

## Requirements
- R1: While either `por_bias_ok` or `por_vin_ok` is low, `drv_en`, `pgood`, `cmd_ready` and `ref_code` stay 0, and an enable rise starts nothing.
- R2: On a rising edge of `enable` (with both POR flags high), the index {`cfg_b`,`cfg_a`} (`cfg_b` is the MSB) selects entry 0..3 of `BOOT_TABLE` (entry k in bits k*CODE_W upward). That entry becomes the boot code. Later changes on the config pins have no effect.
- R3: The soft-start begins at `ref_code`=0 and moves by exactly one code every PRESCALE cycles. No step occurs other than on a tick.
- R4: `pgood` rises when the reference equals the boot code. For boot code n, it is first seen high n*PRESCALE+2 falling edges after `enable` is set at a falling edge. `pgood` implies `drv_en`.
- R5: `cmd_ready` is high only when `pgood` and `cpu_rdy` are both high. A transfer (`cmd_valid`&&`cmd_ready`) replaces the target with `cmd_code`.
- R6: After a transfer, the reference ramps up or down to the new target at the same one-step-per-tick rate, and `pgood` stays high throughout.
- R7: A command accepted during a ramp retargets it. The reference continues from its current value and does not first reach the old target.
- R8: While `cpu_rdy` is low, the reference ramps back to the boot code and `cmd_ready` is 0.
- R9: When `enable` falls, `drv_en`, `pgood` and `ref_code` are 0 one cycle later.
- R10: Loss of either POR flag shuts down as in R9 and clears the boot code. Restoring the flag while `enable` stays high does not restart the block; only a new enable rise does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_bias_ok | input | 1 | Bias supply POR flag |
| por_vin_ok | input | 1 | Input supply POR flag |
| enable | input | 1 | Regulator enable |
| cpu_rdy | input | 1 | Processor-ready |
| cfg_a | input | 1 | Boot select bit 0 |
| cfg_b | input | 1 | Boot select bit 1 |
| cmd_valid | input | 1 | Command valid |
| cmd_code | input | CODE_W | Command target code |
| cmd_ready | output | 1 | Command ready (back-pressure) |
| ref_code | output | CODE_W | Reference code to DAC |
| pgood | output | 1 | Power-good |
| drv_en | output | 1 | Output driver enable |

## Verification
The assertions check the following on every cycle:
- The reference never moves by more than one code, and never moves off a prescaler tick.
- `pgood` implies `drv_en`.
- `cmd_ready` obeys its gating rule.
- A POR loss or an enable fall forces shutdown on the next cycle.

Only the bench scenarios can show the rest:
- The table lookup from the config pins.
- The exact soft-start duration.
- A command sent mid-ramp really retargets the ramp.
- Dropping processor-ready returns the reference to the stored boot level.
- A restored POR flag with enable held high leaves the block off.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SOFT = 2'd1,
    ST_ON   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/vid_tick_gen.sv
module vid_tick_gen #(
  parameter int PRESCALE = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vid_ramp.sv
module vid_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] ref_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run)              ref_q <= '0;
    else if (tick && ref_q < target) ref_q <= ref_q + 1'b1;
    else if (tick && ref_q > target) ref_q <= ref_q - 1'b1;
  end

  // R3: at most one code per cycle while running
  p_one_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (ref_q == $past(ref_q) ||
      ref_q == $past(ref_q) + 1'b1 || ref_q == $past(ref_q) - 1'b1));

  // R3: the reference only moves on a tick
  p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && ref_q != $past(ref_q)) |-> $past(tick));
endmodule

// File: rtl/vid_seq_ctrl.sv
module vid_seq_ctrl
  import vid_seq_pkg::*;
#(
  parameter int                  CODE_W     = 8,
  parameter logic [4*CODE_W-1:0] BOOT_TABLE = {8'd40, 8'd30, 8'd20, 8'd10}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              enable,
  input  logic              cpu_rdy,
  input  logic [1:0]        boot_sel,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [CODE_W-1:0] ref_q,
  output logic              cmd_ready,
  output logic [CODE_W-1:0] target,
  output logic              run,
  output logic              pgood
);
  seq_state_t        state;
  logic              en_q;
  logic [CODE_W-1:0] hold_code;
  logic [CODE_W-1:0] boot_lookup;

  assign boot_lookup = BOOT_TABLE[boot_sel*CODE_W +: CODE_W];
  assign run         = (state != ST_OFF);
  assign cmd_ready   = (state == ST_ON) && cpu_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      en_q      <= 1'b0;
      hold_code <= '0;
      target    <= '0;
      pgood     <= 1'b0;
    end else begin
      en_q <= enable;
      if (!por_ok) begin
        state     <= ST_OFF;
        hold_code <= '0;
        target    <= '0;
        pgood     <= 1'b0;
      end else begin
        unique case (state)
          ST_OFF: if (enable && !en_q) begin
            hold_code <= boot_lookup;
            target    <= boot_lookup;
            state     <= ST_SOFT;
          end
          ST_SOFT: if (!enable) begin
            state <= ST_OFF;
          end else if (ref_q == target) begin
            pgood <= 1'b1;
            state <= ST_ON;
          end
          ST_ON: if (!enable) begin
            state <= ST_OFF;
            pgood <= 1'b0;
          end else if (!cpu_rdy) begin
            target <= hold_code;
          end else if (cmd_valid) begin
            target <= cmd_code;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  p_por_shutdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (!run && !pgood));

  p_enable_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !enable) |=> (!run && !pgood));

  p_pgood_drv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> run);

  p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pgood && cpu_rdy));
endmodule

// File: rtl/vid_startup_seq.sv
module vid_startup_seq #(
  parameter int                  CODE_W     = 8,
  parameter int                  PRESCALE   = 250,
  parameter logic [4*CODE_W-1:0] BOOT_TABLE = {8'd40, 8'd30, 8'd20, 8'd10}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_bias_ok,
  input  logic              por_vin_ok,
  input  logic              enable,
  input  logic              cpu_rdy,
  input  logic              cfg_a,
  input  logic              cfg_b,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              cmd_ready,
  output logic [CODE_W-1:0] ref_code,
  output logic              pgood,
  output logic              drv_en
);
  logic              por_ok;
  logic              run;
  logic              tick;
  logic [CODE_W-1:0] target;
  logic [CODE_W-1:0] ref_q;

  assign por_ok   = por_bias_ok && por_vin_ok;
  assign drv_en   = run;
  assign ref_code = run ? ref_q : '0;

  vid_seq_ctrl #(.CODE_W(CODE_W), .BOOT_TABLE(BOOT_TABLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .enable(enable),
    .cpu_rdy(cpu_rdy), .boot_sel({cfg_b, cfg_a}), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .ref_q(ref_q), .cmd_ready(cmd_ready),
    .target(target), .run(run), .pgood(pgood)
  );

  vid_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  vid_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .target(target), .ref_q(ref_q)
  );

  // R1: outputs quiet while either POR flag is low
  p_quiet_no_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (ref_code == '0 && !drv_en && !cmd_ready));
endmodule

// File: tb/vid_startup_seq_tb.sv
module vid_startup_seq_tb;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_bias_ok = 1'b0, por_vin_ok = 1'b0;
  logic       enable = 1'b0, cpu_rdy = 1'b0, cfg_a = 1'b0, cfg_b = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       cmd_ready, pgood, drv_en;
  logic [7:0] ref_code;

  int pass_cnt = 0, total_cnt = 0;
  int cyc = 0;
  logic watch_pg = 1'b0, pg_drop = 1'b0;
  logic [7:0] max_seen = '0;

  always #4 clk = ~clk;

  vid_startup_seq #(.CODE_W(8), .PRESCALE(P),
                    .BOOT_TABLE({8'd40, 8'd30, 8'd20, 8'd10})) u_dut (
    .clk(clk), .rst_n(rst_n), .por_bias_ok(por_bias_ok), .por_vin_ok(por_vin_ok),
    .enable(enable), .cpu_rdy(cpu_rdy), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
    .ref_code(ref_code), .pgood(pgood), .drv_en(drv_en)
  );

  always @(negedge clk) begin
    cyc++;
    if (watch_pg && !pgood) pg_drop = 1'b1;
    if (ref_code > max_seen) max_seen = ref_code;
  end

  typedef struct packed { logic [1:0] sel; logic [7:0] code; } vec_t;
  localparam vec_t VECS [4] = '{
    '{sel: 2'd2, code: 8'd30}, '{sel: 2'd0, code: 8'd10},
    '{sel: 2'd3, code: 8'd40}, '{sel: 2'd1, code: 8'd20}};

  task automatic check(input string req, input int act, input int exp);
    total_cnt++;
    if (act == exp) pass_cnt++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic wait_ref(input logic [7:0] t, input int limit);
    int n = 0;
    while (ref_code != t && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    check("R5 ready before send", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic start_boot(input logic [1:0] sel, output int n);
    @(negedge clk);
    {cfg_b, cfg_a} = sel;
    @(negedge clk);
    enable = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; if (n == 3) {cfg_b, cfg_a} = ~sel; end
    while (!pgood && n < 2000);
  endtask

  initial begin
    int n;
    por_bias_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and single POR flag blocks start
    check("R1 drv_en reset", drv_en, 0);
    check("R1 pgood reset", pgood, 0);
    check("R1 ref reset", ref_code, 0);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 no start with one POR", drv_en, 0);
    check("R1 cmd_ready off", cmd_ready, 0);
    enable = 1'b0;
    por_vin_ok = 1'b1;
    @(negedge clk);

    // R2 R3 R4: boot table walk
    foreach (VECS[i]) begin
      start_boot(VECS[i].sel, n);
      check("R2 boot code latched", ref_code, VECS[i].code);
      check("R4 soft-start duration", n, VECS[i].code * P + 2);
      check("R4 drv_en with pgood", drv_en, 1);
      @(negedge clk); enable = 1'b0;
      @(negedge clk);
      check("R9 off after enable fall", {drv_en, pgood}, 0);
      check("R9 ref zero", ref_code, 0);
    end

    // command ramps, boot = 10
    start_boot(2'd0, n);
    cpu_rdy = 1'b1;
    @(negedge clk);
    watch_pg = 1'b1;
    send_cmd(8'd25);
    wait_ref(8'd25, 20 * P);
    check("R6 ramp up target", ref_code, 25);
    send_cmd(8'd5);
    wait_ref(8'd5, 25 * P);
    check("R6 ramp down target", ref_code, 5);
    repeat (3 * P) @(negedge clk);
    check("R6 holds target", ref_code, 5);
    check("R6 pgood kept", pg_drop, 0);

    // R7: retarget mid-ramp
    max_seen = '0;
    send_cmd(8'd40);
    repeat (8 * P) @(negedge clk);
    send_cmd(8'd12);
    wait_ref(8'd12, 20 * P);
    repeat (4 * P) @(negedge clk);
    check("R7 final retarget", ref_code, 12);
    check("R7 old target not reached", int'(max_seen < 8'd25), 1);

    // R8: processor-ready drops, return to boot, commands blocked
    @(negedge clk);
    cpu_rdy = 1'b0;
    cmd_valid = 1'b1; cmd_code = 8'd50;
    @(negedge clk);
    check("R8 cmd_ready low", cmd_ready, 0);
    wait_ref(8'd10, 10 * P);
    repeat (3 * P) @(negedge clk);
    check("R8 back to boot", ref_code, 10);
    check("R8 pgood kept", pg_drop, 0);
    cmd_valid = 1'b0;
    watch_pg = 1'b0;

    // R10: POR loss with enable held high
    @(negedge clk);
    por_vin_ok = 1'b0;
    @(negedge clk);
    check("R10 drv_en off", drv_en, 0);
    check("R10 pgood off", pgood, 0);
    por_vin_ok = 1'b1;
    repeat (5 * P) @(negedge clk);
    check("R10 no restart on POR return", drv_en, 0);
    check("R10 ref stays zero", ref_code, 0);
    enable = 1'b0;
    start_boot(2'd1, n);
    check("R10 restart on new enable rise", ref_code, 20);

    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end
endmodule